// File: doc/BRIEF.md
# Per-Second Packet Loss Performance Monitor

This block watches the receive side of a constant-bit-rate packet emulation service and turns per-packet events into per-second error-performance counts. Each clock it may see a pulse for a packet received (optionally carrying the remote-defect flag) and a pulse for a packet found lost. It also sees a loss-of-signal defect level. A one-second tick closes each measurement interval. At the tick the interval's loss ratio is classified against a configurable degrade threshold and a fixed 15% severity limit. The block keeps a degradation defect with hysteresis.

Near-end errored, severely errored and unavailable second counters are kept with entry and exit hysteresis. Entering unavailable time retroactively withdraws the errored and severely errored seconds of the entry run. Leaving unavailable time credits the errored seconds seen during the clearing run back. A second, independent counter set is driven by the remote-defect flag carried in received packets.

Top module: `loss_perf_monitor`

## Requirements
- R1: An interval holds the pulses and PLOS level sampled in the cycles after one tick up to the cycle before the next tick. Pulses present in the tick cycle itself belong to the following interval. Counters change only in the second clock cycle after the tick is sampled.
- R2: An interval exceeds the degrade threshold when lost*100 > cfg_sd_pct*(received+lost), evaluated without division. An interval with no received and no lost packets counts as 100% loss.
- R3: `deg` sets after cfg_deg_n consecutive intervals over the threshold. It clears after cfg_deg_n consecutive intervals at or below it. The interval that completes the run already carries the new value.
- R4: A near-end second is errored when at least one packet was lost, PLOS was seen during the interval, `deg` is set, or the interval was empty.
- R5: A near-end second is severely errored when lost*100 > 15*(received+lost), PLOS was seen, `deg` is set, or the interval was empty. Every severely errored second is also errored.
- R6: While available, a severely errored second that completes a run of cfg_uas_enter consecutive ones makes the counter set unavailable. The errored and severely errored seconds already counted for that run are subtracted. The unavailable count grows by the full run length.
- R7: While unavailable, each second adds one unavailable second. A non-severe second that completes a run of cfg_uas_exit consecutive ones makes the set available again. The tentative unavailable seconds of that run are removed, and the errored seconds seen during the run are added.
- R8: The far-end set uses the same availability rules. A second is far-end errored when at least one received packet carried the flag. It is far-end severely errored when flagged*100 > 15*received.
- R9: Every counter saturates at all ones. A saturated counter keeps its value, and no withdrawal is applied to it.
- R10: After reset all counters are zero, `deg` is low and both sets are available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_rx | input | 1 | One received packet this cycle |
| rx_rflag | input | 1 | The received packet carries the remote-defect flag |
| pkt_lost | input | 1 | One packet declared lost this cycle |
| plos | input | 1 | Packet loss-of-signal defect level |
| sec_tick | input | 1 | One-cycle pulse closing the interval |
| cfg_sd_pct | input | 7 | Degrade threshold in percent (1..100) |
| cfg_deg_n | input | DEGN_W | Consecutive intervals to set or clear `deg` (2..10) |
| cfg_uas_enter | input | RUN_W | Consecutive severe seconds to enter unavailable time |
| cfg_uas_exit | input | RUN_W | Consecutive non-severe seconds to leave it |
| deg | output | 1 | Degradation defect |
| ne_es_cnt | output | PM_W | Near-end errored seconds |
| ne_ses_cnt | output | PM_W | Near-end severely errored seconds |
| ne_uas_cnt | output | PM_W | Near-end unavailable seconds |
| ne_unavail | output | 1 | Near-end set is in unavailable time |
| fe_es_cnt | output | PM_W | Far-end errored seconds |
| fe_ses_cnt | output | PM_W | Far-end severely errored seconds |
| fe_uas_cnt | output | PM_W | Far-end unavailable seconds |
| fe_unavail | output | 1 | Far-end set is in unavailable time |

## Verification
The hardest situation to reach is one where a degrade run, an unavailability entry and its later clearing overlap. In that case `deg` keeps seconds severe after the loss itself has stopped. The stimulus builds this deliberately: a few intervals of 40% loss declare `deg` and enter unavailable time in the same run. Clean intervals follow, which first clear `deg` and then complete a clearing run containing one lightly errored second. The withdrawal, the add-back and the unavailable correction are therefore all seen in one sequence. A lost pulse placed on the tick cycle, an empty interval and a long run that drives a reduced-width counter into saturation cover the remaining edges.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  // Severity limit for a severely errored second, in percent
  localparam int unsigned SEV_PCT = 15;

  // Per-interval classification handed from the accumulator to the counters
  typedef struct packed {
    logic sd_over;     // loss ratio above the degrade threshold
    logic ne_es_base;  // errored before the degrade defect is added
    logic ne_ses_base; // severe before the degrade defect is added
    logic fe_es;       // far-end errored
    logic fe_ses;      // far-end severe
  } sec_flags_t;
endpackage

// File: rtl/lpm_interval_acc.sv
module lpm_interval_acc
  import lpm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pkt_rx,
  input  logic             rx_rflag,
  input  logic             pkt_lost,
  input  logic             plos,
  input  logic             sec_tick,
  input  logic [6:0]       cfg_sd_pct,
  output logic             ev_valid,
  output sec_flags_t       ev_flags
);
  localparam int PROD_W = CNT_W + 8;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] rx_cnt, lost_cnt, rf_cnt;
  logic             plos_seen;

  logic [PROD_W-1:0] tot_w, lost_w, rx_w, rf_w;
  logic              empty_iv;
  sec_flags_t        flags_c;

  always_comb begin
    rx_w     = PROD_W'(rx_cnt);
    lost_w   = PROD_W'(lost_cnt);
    rf_w     = PROD_W'(rf_cnt);
    tot_w    = rx_w + lost_w;
    empty_iv = (tot_w == '0);
    flags_c.sd_over     = empty_iv || (lost_w * PROD_W'(100) > PROD_W'(cfg_sd_pct) * tot_w);
    flags_c.ne_ses_base = empty_iv || plos_seen ||
                          (lost_w * PROD_W'(100) > PROD_W'(SEV_PCT) * tot_w);
    flags_c.ne_es_base  = empty_iv || plos_seen || (lost_cnt != '0);
    flags_c.fe_es       = (rf_cnt != '0);
    flags_c.fe_ses      = (rf_w * PROD_W'(100) > PROD_W'(SEV_PCT) * rx_w);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_cnt    <= '0;
      lost_cnt  <= '0;
      rf_cnt    <= '0;
      plos_seen <= 1'b0;
      ev_valid  <= 1'b0;
      ev_flags  <= '0;
    end else if (sec_tick) begin
      // the tick cycle's own events open the next interval
      rx_cnt    <= CNT_W'(pkt_rx);
      lost_cnt  <= CNT_W'(pkt_lost);
      rf_cnt    <= CNT_W'(pkt_rx & rx_rflag);
      plos_seen <= plos;
      ev_valid  <= 1'b1;
      ev_flags  <= flags_c;
    end else begin
      if (pkt_rx && rx_cnt != CNT_MAX)               rx_cnt   <= rx_cnt + 1'b1;
      if (pkt_lost && lost_cnt != CNT_MAX)           lost_cnt <= lost_cnt + 1'b1;
      if (pkt_rx && rx_rflag && rf_cnt != CNT_MAX)   rf_cnt   <= rf_cnt + 1'b1;
      plos_seen <= plos_seen | plos;
      ev_valid  <= 1'b0;
    end
  end

  assert_eval_follows_tick_R1: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> $past(sec_tick));
endmodule

// File: rtl/lpm_deg_detect.sv
module lpm_deg_detect #(
  parameter int DEGN_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic              sd_over,
  input  logic [DEGN_W-1:0] cfg_deg_n,
  output logic              deg
);
  localparam logic [DEGN_W:0] ONE = (DEGN_W+1)'(1);

  logic [DEGN_W-1:0] bad_run, good_run;
  logic              bad_done, good_done;

  assign bad_done  = ({1'b0, bad_run}  + ONE) >= {1'b0, cfg_deg_n};
  assign good_done = ({1'b0, good_run} + ONE) >= {1'b0, cfg_deg_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      deg      <= 1'b0;
      bad_run  <= '0;
      good_run <= '0;
    end else if (ev_valid) begin
      if (sd_over) begin
        good_run <= '0;
        if (!deg) begin
          if (bad_done) begin
            deg     <= 1'b1;
            bad_run <= '0;
          end else begin
            bad_run <= bad_run + 1'b1;
          end
        end
      end else begin
        bad_run <= '0;
        if (deg) begin
          if (good_done) begin
            deg      <= 1'b0;
            good_run <= '0;
          end else begin
            good_run <= good_run + 1'b1;
          end
        end
      end
    end
  end

  assert_deg_moves_on_eval_R3: assert property (@(posedge clk) disable iff (rst)
    (deg != $past(deg)) |-> $past(ev_valid));
  assert_deg_needs_over_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(deg) |-> $past(sd_over));
endmodule

// File: rtl/lpm_avail_ctr.sv
module lpm_avail_ctr #(
  parameter int PM_W  = 32,
  parameter int RUN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sec_valid,
  input  logic             sec_es,
  input  logic             sec_ses,
  input  logic [RUN_W-1:0] cfg_enter,
  input  logic [RUN_W-1:0] cfg_exit,
  output logic [PM_W-1:0]  es_cnt,
  output logic [PM_W-1:0]  ses_cnt,
  output logic [PM_W-1:0]  uas_cnt,
  output logic             unavail
);
  localparam logic [RUN_W:0]  ONE = (RUN_W+1)'(1);
  localparam logic [PM_W-1:0] MAXV = '1;

  logic [RUN_W-1:0] ses_run, clr_run, pend_es;
  logic             enter_now, exit_now;

  function automatic logic [PM_W-1:0] sat_add(input logic [PM_W-1:0] a,
                                              input logic [PM_W-1:0] b);
    logic [PM_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[PM_W] ? MAXV : s[PM_W-1:0];
  endfunction

  function automatic logic [PM_W-1:0] sat_sub(input logic [PM_W-1:0] a,
                                              input logic [PM_W-1:0] b);
    return (a == MAXV) ? a : a - b;
  endfunction

  assign enter_now = ({1'b0, ses_run} + ONE) >= {1'b0, cfg_enter};
  assign exit_now  = ({1'b0, clr_run} + ONE) >= {1'b0, cfg_exit};

  always_ff @(posedge clk) begin
    if (rst) begin
      es_cnt  <= '0;
      ses_cnt <= '0;
      uas_cnt <= '0;
      unavail <= 1'b0;
      ses_run <= '0;
      clr_run <= '0;
      pend_es <= '0;
    end else if (sec_valid) begin
      if (!unavail) begin
        if (sec_ses) begin
          if (enter_now) begin
            unavail <= 1'b1;
            es_cnt  <= sat_sub(es_cnt,  PM_W'(ses_run));
            ses_cnt <= sat_sub(ses_cnt, PM_W'(ses_run));
            uas_cnt <= sat_add(uas_cnt, PM_W'(ses_run) + PM_W'(1));
            ses_run <= '0;
            clr_run <= '0;
            pend_es <= '0;
          end else begin
            ses_run <= ses_run + 1'b1;
            es_cnt  <= sat_add(es_cnt,  PM_W'(1));
            ses_cnt <= sat_add(ses_cnt, PM_W'(1));
          end
        end else begin
          ses_run <= '0;
          if (sec_es) es_cnt <= sat_add(es_cnt, PM_W'(1));
        end
      end else begin
        if (sec_ses) begin
          clr_run <= '0;
          pend_es <= '0;
          uas_cnt <= sat_add(uas_cnt, PM_W'(1));
        end else if (exit_now) begin
          unavail <= 1'b0;
          uas_cnt <= sat_sub(uas_cnt, PM_W'(clr_run));
          es_cnt  <= sat_add(es_cnt, PM_W'(pend_es) + PM_W'(sec_es));
          clr_run <= '0;
          pend_es <= '0;
        end else begin
          clr_run <= clr_run + 1'b1;
          pend_es <= pend_es + RUN_W'(sec_es);
          uas_cnt <= sat_add(uas_cnt, PM_W'(1));
        end
      end
    end
  end

  assert_quiet_between_seconds_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(sec_valid) |-> ($stable(es_cnt) && $stable(ses_cnt) && $stable(uas_cnt)));
  assert_ses_within_es_R5: assert property (@(posedge clk) disable iff (rst)
    ses_cnt <= es_cnt);
  assert_es_drop_on_entry_R6: assert property (@(posedge clk) disable iff (rst)
    (es_cnt < $past(es_cnt)) |-> (unavail && !$past(unavail)));
  assert_uas_grows_unavail_R7: assert property (@(posedge clk) disable iff (rst)
    (uas_cnt > $past(uas_cnt)) |-> unavail);
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(es_cnt) == MAXV) |-> (es_cnt == MAXV));
endmodule

// File: rtl/loss_perf_monitor.sv
module loss_perf_monitor
  import lpm_pkg::*;
#(
  parameter int PM_W   = 32,
  parameter int CNT_W  = 16,
  parameter int RUN_W  = 8,
  parameter int DEGN_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_rx,
  input  logic              rx_rflag,
  input  logic              pkt_lost,
  input  logic              plos,
  input  logic              sec_tick,
  input  logic [6:0]        cfg_sd_pct,
  input  logic [DEGN_W-1:0] cfg_deg_n,
  input  logic [RUN_W-1:0]  cfg_uas_enter,
  input  logic [RUN_W-1:0]  cfg_uas_exit,
  output logic              deg,
  output logic [PM_W-1:0]   ne_es_cnt,
  output logic [PM_W-1:0]   ne_ses_cnt,
  output logic [PM_W-1:0]   ne_uas_cnt,
  output logic              ne_unavail,
  output logic [PM_W-1:0]   fe_es_cnt,
  output logic [PM_W-1:0]   fe_ses_cnt,
  output logic [PM_W-1:0]   fe_uas_cnt,
  output logic              fe_unavail
);
  logic       ev_valid, sec_done;
  sec_flags_t ev_flags, flags_q;
  logic       ne_es, ne_ses;

  lpm_interval_acc #(.CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst(rst), .pkt_rx(pkt_rx), .rx_rflag(rx_rflag),
    .pkt_lost(pkt_lost), .plos(plos), .sec_tick(sec_tick),
    .cfg_sd_pct(cfg_sd_pct), .ev_valid(ev_valid), .ev_flags(ev_flags)
  );

  lpm_deg_detect #(.DEGN_W(DEGN_W)) u_deg (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .sd_over(ev_flags.sd_over),
    .cfg_deg_n(cfg_deg_n), .deg(deg)
  );

  // align the interval flags with the updated degrade state
  always_ff @(posedge clk) begin
    if (rst) begin
      sec_done <= 1'b0;
      flags_q  <= '0;
    end else begin
      sec_done <= ev_valid;
      if (ev_valid) flags_q <= ev_flags;
    end
  end

  assign ne_es  = flags_q.ne_es_base  | deg;
  assign ne_ses = flags_q.ne_ses_base | deg;

  lpm_avail_ctr #(.PM_W(PM_W), .RUN_W(RUN_W)) u_near (
    .clk(clk), .rst(rst), .sec_valid(sec_done), .sec_es(ne_es), .sec_ses(ne_ses),
    .cfg_enter(cfg_uas_enter), .cfg_exit(cfg_uas_exit),
    .es_cnt(ne_es_cnt), .ses_cnt(ne_ses_cnt), .uas_cnt(ne_uas_cnt), .unavail(ne_unavail)
  );

  lpm_avail_ctr #(.PM_W(PM_W), .RUN_W(RUN_W)) u_far (
    .clk(clk), .rst(rst), .sec_valid(sec_done), .sec_es(flags_q.fe_es),
    .sec_ses(flags_q.fe_ses), .cfg_enter(cfg_uas_enter), .cfg_exit(cfg_uas_exit),
    .es_cnt(fe_es_cnt), .ses_cnt(fe_ses_cnt), .uas_cnt(fe_uas_cnt), .unavail(fe_unavail)
  );

  assert_deg_counts_severe_R5: assert property (@(posedge clk) disable iff (rst)
    (sec_done && deg && !ne_unavail) |=> (ne_ses_cnt != $past(ne_ses_cnt) || ne_unavail
                                          || ne_ses_cnt == '1));
endmodule

// File: tb/test_loss_perf_monitor.sv
module test_loss_perf_monitor;
  localparam int PM_W = 6;
  localparam int MAXV = (1 << PM_W) - 1;
  localparam int SD = 30, DEGN = 3, ENTER = 4, EXIT = 3;

  logic clk = 0, rst = 1;
  logic pkt_rx = 0, rx_rflag = 0, pkt_lost = 0, plos = 0, sec_tick = 0;
  logic deg, ne_unavail, fe_unavail;
  logic [PM_W-1:0] ne_es_cnt, ne_ses_cnt, ne_uas_cnt, fe_es_cnt, fe_ses_cnt, fe_uas_cnt;

  always #4 clk = ~clk;  // 125 MHz

  loss_perf_monitor #(.PM_W(PM_W)) i_loss_perf_monitor (
    .clk(clk), .rst(rst), .pkt_rx(pkt_rx), .rx_rflag(rx_rflag), .pkt_lost(pkt_lost),
    .plos(plos), .sec_tick(sec_tick), .cfg_sd_pct(7'(SD)), .cfg_deg_n(4'(DEGN)),
    .cfg_uas_enter(8'(ENTER)), .cfg_uas_exit(8'(EXIT)), .deg(deg),
    .ne_es_cnt(ne_es_cnt), .ne_ses_cnt(ne_ses_cnt), .ne_uas_cnt(ne_uas_cnt),
    .ne_unavail(ne_unavail), .fe_es_cnt(fe_es_cnt), .fe_ses_cnt(fe_ses_cnt),
    .fe_uas_cnt(fe_uas_cnt), .fe_unavail(fe_unavail)
  );

  typedef struct packed {
    int dg; int nes; int nses; int nuas; int nun; int fes; int fses; int fuas; int fun;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference state, indexed 0 = near end, 1 = far end
  int m_es[2], m_ses[2], m_uas[2], m_un[2], m_run[2], m_clr[2], m_pend[2];
  int m_deg = 0, m_bad = 0, m_good = 0, carry_lost = 0;

  function automatic int sadd(int a, int b);
    return (a + b > MAXV) ? MAXV : a + b;
  endfunction
  function automatic int ssub(int a, int b);
    return (a == MAXV) ? a : a - b;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic avail_step(int k, bit es, bit ses);
    if (m_un[k] == 0) begin
      if (ses) begin
        if (m_run[k] + 1 >= ENTER) begin  // R6 entry
          m_un[k] = 1;
          m_es[k] = ssub(m_es[k], m_run[k]);
          m_ses[k] = ssub(m_ses[k], m_run[k]);
          m_uas[k] = sadd(m_uas[k], m_run[k] + 1);
          m_run[k] = 0; m_clr[k] = 0; m_pend[k] = 0;
        end else begin
          m_run[k]++;
          m_es[k] = sadd(m_es[k], 1);
          m_ses[k] = sadd(m_ses[k], 1);
        end
      end else begin
        m_run[k] = 0;
        if (es) m_es[k] = sadd(m_es[k], 1);
      end
    end else begin
      if (ses) begin
        m_clr[k] = 0; m_pend[k] = 0;
        m_uas[k] = sadd(m_uas[k], 1);
      end else if (m_clr[k] + 1 >= EXIT) begin  // R7 exit
        m_un[k] = 0;
        m_uas[k] = ssub(m_uas[k], m_clr[k]);
        m_es[k] = sadd(m_es[k], m_pend[k] + int'(es));
        m_clr[k] = 0; m_pend[k] = 0;
      end else begin
        m_clr[k]++;
        m_pend[k] += int'(es);
        m_uas[k] = sadd(m_uas[k], 1);
      end
    end
  endtask

  task automatic model_second(int rx, int lost, int r, bit pl);
    int tot;
    bit empty, sd, sev, es, ses;
    exp_t e;
    tot = rx + lost;
    empty = (tot == 0);
    sd  = empty || (lost * 100 > SD * tot);   // R2
    sev = empty || (lost * 100 > 15 * tot);
    if (sd) begin                             // R3
      m_good = 0;
      if (m_deg == 0) begin
        if (m_bad + 1 >= DEGN) begin m_deg = 1; m_bad = 0; end else m_bad++;
      end
    end else begin
      m_bad = 0;
      if (m_deg == 1) begin
        if (m_good + 1 >= DEGN) begin m_deg = 0; m_good = 0; end else m_good++;
      end
    end
    es  = empty || lost > 0 || pl || m_deg == 1;  // R4
    ses = sev || pl || m_deg == 1;                // R5
    avail_step(0, es, ses);
    avail_step(1, r > 0, r * 100 > 15 * rx);      // R8
    e.dg = m_deg; e.nes = m_es[0]; e.nses = m_ses[0]; e.nuas = m_uas[0]; e.nun = m_un[0];
    e.fes = m_es[1]; e.fses = m_ses[1]; e.fuas = m_uas[1]; e.fun = m_un[1];
    q.push_back(e);
  endtask

  // driver: one measurement interval, lost_tick puts a lost pulse on the tick cycle (R1)
  task automatic run_second(int rx, int lost, int r, bit pl, bit lost_tick);
    for (int i = 0; i < rx; i++) begin
      @(negedge clk); pkt_rx = 1; rx_rflag = (i < r);
      @(negedge clk); pkt_rx = 0; rx_rflag = 0;
    end
    for (int i = 0; i < lost; i++) begin
      @(negedge clk); pkt_lost = 1;
      @(negedge clk); pkt_lost = 0;
    end
    if (pl) begin
      @(negedge clk); plos = 1;
      @(negedge clk); plos = 0;
    end
    model_second(rx, lost + carry_lost, r, pl);
    carry_lost = int'(lost_tick);
    @(negedge clk); sec_tick = 1; pkt_lost = lost_tick;
    @(negedge clk); sec_tick = 0; pkt_lost = 0;
    repeat (6) @(negedge clk);
  endtask

  // monitor: counters settle two edges after the tick is sampled
  initial begin
    exp_t e;
    forever begin
      @(posedge clk iff sec_tick == 1'b1);
      repeat (3) @(posedge clk);
      @(negedge clk);
      if (q.size() == 0) begin
        chk("R1", "unexpected interval", 1, 0);
      end else begin
        e = q.pop_front();
        chk("R3", "deg", int'(deg), e.dg);
        chk("R4", "ne_es_cnt", int'(ne_es_cnt), e.nes);
        chk("R5", "ne_ses_cnt", int'(ne_ses_cnt), e.nses);
        chk("R6", "ne_uas_cnt", int'(ne_uas_cnt), e.nuas);
        chk("R7", "ne_unavail", int'(ne_unavail), e.nun);
        chk("R8", "fe_es_cnt", int'(fe_es_cnt), e.fes);
        chk("R8", "fe_ses_cnt", int'(fe_ses_cnt), e.fses);
        chk("R8", "fe_uas_cnt", int'(fe_uas_cnt), e.fuas);
        chk("R8", "fe_unavail", int'(fe_unavail), e.fun);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      m_es[k] = 0; m_ses[k] = 0; m_uas[k] = 0; m_un[k] = 0;
      m_run[k] = 0; m_clr[k] = 0; m_pend[k] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk("R10", "deg", int'(deg), 0);
    chk("R10", "ne_es_cnt", int'(ne_es_cnt), 0);
    chk("R10", "ne_uas_cnt", int'(ne_uas_cnt), 0);
    chk("R10", "ne_unavail", int'(ne_unavail), 0);
    chk("R10", "fe_ses_cnt", int'(fe_ses_cnt), 0);

    run_second(10, 0, 0, 0, 0);   // clean
    run_second(10, 1, 0, 0, 0);   // R4 light loss: errored only
    run_second(8, 2, 0, 0, 0);    // R5 20%: severe, below degrade threshold
    run_second(10, 0, 0, 0, 0);   // breaks the severe run
    run_second(0, 0, 0, 0, 0);    // R2 empty interval counts as full loss
    run_second(6, 4, 0, 0, 0);    // 40% over threshold
    run_second(6, 4, 0, 0, 0);    // R3 third over-threshold interval sets deg
    run_second(6, 4, 0, 0, 0);    // R6 fourth severe second enters unavailable time
    run_second(10, 0, 0, 0, 0);   // deg holds the second severe
    run_second(10, 0, 0, 0, 0);
    run_second(10, 0, 0, 0, 0);   // R3 deg clears, clearing run starts
    run_second(10, 1, 0, 0, 0);   // errored second inside clearing run
    run_second(10, 0, 0, 0, 0);   // R7 exit, add-back
    run_second(10, 0, 0, 1, 0);   // R4 R5 PLOS seen
    run_second(10, 0, 0, 0, 1);   // R1 lost pulse on tick belongs to next interval
    run_second(10, 0, 0, 0, 0);   // carries that lost pulse
    run_second(10, 0, 1, 0, 0);   // R8 far end errored, not severe
    run_second(10, 0, 3, 0, 0);   // far end severe
    for (int s = 0; s < 4; s++) run_second(10, 0, 5, 0, 0);  // far end enters
    for (int s = 0; s < 3; s++) run_second(10, 0, 0, 0, 0);  // far end exits
    for (int s = 0; s < 70; s++) run_second(9, 1, 0, 0, 0);  // R9 saturation
    chk("R9", "ne_es_cnt saturated", int'(ne_es_cnt), MAXV);

    repeat (10) @(negedge clk);
    chk("R1", "queue drained", q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule